// File: doc/BRIEF.md
# Guarded Index/Data Configuration Port

This block gives a processor access to a small bank of chipset configuration bytes through two adjacent I/O addresses. A write to the lower address picks a register by number, and the higher address then reads or writes the chosen register. The processor side is reduced to a read strobe, a write strobe, an address and one data byte. The block does not model the bus protocol.

A guard flag protects the bank. Every data write is refused until a key byte has been written to a dedicated register number. Even when the guard is open, only a few register numbers take writes. Register 0 controls a single output that selects the system's configuration access mechanism. The output is high unless register 0 was last written with one specific code. It is held low from reset until register 0 is first written.

Top module: `cfg_index_port`

## Requirements
- R1: A write to address 0x22 loads the 8-bit index. A read of 0x22 returns the index on `bus_rdata` in the same cycle. The index resets to 0x00.
- R2: A write to address 0x23 while the index is 0x03 closes the guard if the byte differs from 0x69. It opens the guard if the byte equals 0x69.
- R3: While the guard is closed, no write to 0x23 changes any register.
- R4: While the guard is open, a write to 0x23 updates the indexed register only for indices 0x00, 0x06 and 0x07. Writes to any other index leave every register unchanged.
- R5: A read of 0x23 returns the indexed register when the index is below 0x10. It returns 0xFF for an index of 0x10 or above.
- R6: The cycle after an accepted write to register 0, `mech_sel` goes to 1 if the byte is not 0xC8, and to 0 if it is 0xC8. No other write changes `mech_sel`.
- R7: After reset, registers 1 to 15 hold 0x00 and register 0 holds 0xFF. The guard is closed and `mech_sel` is 0.
- R8: Writes to any address other than 0x22 or 0x23 change nothing. `bus_rdata` is 0xFF for reads of such addresses and whenever `bus_rd` is low.
- R9: The guard state cannot be read. Index 0x03 returns its own storage byte, which is 0x00 after reset and stays 0x00 because that index takes no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | I/O address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, combinational |
| mech_sel | output | 1 | Configuration mechanism select |

## Verification
The assertions check the following on every cycle:
- the index capture;
- the guard's response to the key and to any other byte;
- that the register bank is frozen while the guard is closed or the index is not writable;
- the 0xFF reads for unmapped addresses and out-of-range indices;
- the `mech_sel` update rule.

Only the bench's scenarios show certain behaviours. These are the exact reset contents of all sixteen registers, that accepted data lands in the right register and reads back, that the guard is invisible at index 0x03, and that `mech_sel` stays low after reset even though register 0 holds 0xFF. A randomized phase mixes all four address classes against a reference model to reach orderings that the directed sequences miss.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef logic [7:0] byte_t;

  // next guard state: a write at the guard index closes unless it carries the key
  function automatic logic guard_next(input logic cur, input logic hit,
                                      input byte_t val, input byte_t key);
    return hit ? (val != key) : cur;
  endfunction

  // mechanism level derived from a byte written to register 0
  function automatic logic mech_level(input byte_t val, input byte_t off_code);
    return val != off_code;
  endfunction

  // index addresses the bank when its bits above the select field are zero
  function automatic logic idx_in_bank(input byte_t idx, input int sel_w);
    return (idx >> sel_w) == 8'h00;
  endfunction
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0022
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  localparam logic [ADDR_W-1:0] DAT_PORT = IDX_PORT + 1'b1;

  logic idx_hit, dat_hit;
  assign idx_hit = (addr == IDX_PORT);
  assign dat_hit = (addr == DAT_PORT);

  assign idx_wr = wr & idx_hit;
  assign idx_rd = rd & idx_hit;
  assign dat_wr = wr & dat_hit;
  assign dat_rd = rd & dat_hit;
endmodule

// File: rtl/cfgp_guard.sv
module cfgp_guard
  import cfgp_pkg::*;
#(
  parameter byte_t GUARD_IDX = 8'h03,
  parameter byte_t KEY       = 8'h69
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dat_wr,
  input  byte_t idx,
  input  byte_t wdata,
  output logic  locked_q,
  output logic  lock_nxt
);
  logic guard_hit;
  assign guard_hit = dat_wr && (idx == GUARD_IDX);
  assign lock_nxt  = guard_next(locked_q, guard_hit, wdata, KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) locked_q <= 1'b1;
    else        locked_q <= lock_nxt;
  end

  // R2: a non-key byte at the guard index closes the guard
  assert_close_on_bad_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx == GUARD_IDX && wdata != KEY) |=> locked_q);
  // R2: the key byte at the guard index opens the guard
  assert_open_on_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx == GUARD_IDX && wdata == KEY) |=> !locked_q);
  // R2: the guard holds its state without a guard-index write
  assert_guard_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && idx == GUARD_IDX) |=> $stable(locked_q));
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
  import cfgp_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter logic [NUM_REGS-1:0] WR_MASK = 16'h00C1,
  parameter byte_t REG0_RST = 8'hFF,
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  byte_t                 idx,
  input  byte_t                 wdata,
  output byte_t                 rdata,
  output logic                  in_bank,
  output logic                  idx_writable,
  output logic [NUM_REGS*8-1:0] reg_flat
);
  byte_t            regs [NUM_REGS];
  logic [SEL_W-1:0] sel;

  assign sel          = idx[SEL_W-1:0];
  assign in_bank      = idx_in_bank(idx, SEL_W);
  assign idx_writable = in_bank && WR_MASK[sel];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (WR_MASK[i]) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[i] <= (i == 0) ? REG0_RST : 8'h00;
        else if (wr_en && in_bank && sel == SEL_W'(i))
          regs[i] <= wdata;
      end
    end else begin : g_ro
      always_ff @(posedge clk) begin
        if (!rst_n) regs[i] <= (i == 0) ? REG0_RST : 8'h00;
      end
    end
    assign reg_flat[i*8 +: 8] = regs[i];
  end

  assign rdata = in_bank ? regs[sel] : 8'hFF;
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgp_pkg::*;
#(
  parameter int    ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0022,
  parameter int    NUM_REGS  = 16,
  parameter logic [NUM_REGS-1:0] WR_MASK = 16'h00C1,
  parameter byte_t GUARD_IDX = 8'h03,
  parameter byte_t KEY       = 8'h69,
  parameter byte_t MECH_OFF  = 8'hC8,
  parameter byte_t REG0_RST  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              mech_sel
);
  localparam logic [ADDR_W-1:0] DAT_PORT = IDX_PORT + 1'b1;

  logic  idx_wr, idx_rd, dat_wr, dat_rd;
  logic  locked_q, lock_nxt, accept_wr;
  logic  in_bank, idx_writable;
  byte_t idx_q, bank_rdata;
  logic  mech_q;
  logic [NUM_REGS*8-1:0] reg_flat;

  cfgp_decode #(.ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT)) u_decode (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  cfgp_guard #(.GUARD_IDX(GUARD_IDX), .KEY(KEY)) u_guard (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .idx(idx_q), .wdata(bus_wdata),
    .locked_q(locked_q), .lock_nxt(lock_nxt)
  );

  // the guard is evaluated first, then the write sees the updated state
  assign accept_wr = dat_wr && !lock_nxt;

  cfgp_regbank #(.NUM_REGS(NUM_REGS), .WR_MASK(WR_MASK), .REG0_RST(REG0_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(accept_wr), .idx(idx_q), .wdata(bus_wdata),
    .rdata(bank_rdata), .in_bank(in_bank), .idx_writable(idx_writable),
    .reg_flat(reg_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= 8'h00;
    else if (idx_wr) idx_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mech_q <= 1'b0;
    else if (accept_wr && idx_q == 8'h00)
      mech_q <= mech_level(bus_wdata, MECH_OFF);
  end

  assign mech_sel  = mech_q;
  assign bus_rdata = idx_rd ? idx_q : (dat_rd ? bank_rdata : 8'hFF);

  // R1: the index captures the byte written to the index port
  assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(bus_wdata));
  // R3: the bank is frozen while the guard is closed
  assert_locked_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(reg_flat));
  // R4: non-writable indices leave the bank untouched
  assert_ro_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_writable) |=> $stable(reg_flat));
  // R5: out-of-bank index reads 0xFF
  assert_oob_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DAT_PORT && !in_bank) |-> bus_rdata == 8'hFF);
  // R6: an accepted register-0 write sets the mechanism level
  assert_mech_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_wr && idx_q == 8'h00) |=> mech_sel == ($past(bus_wdata) != MECH_OFF));
  // R6: the mechanism level holds without an accepted register-0 write
  assert_mech_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_wr && idx_q == 8'h00) |=> $stable(mech_sel));
  // R8: unmapped addresses and idle cycles read 0xFF
  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || (bus_addr != IDX_PORT && bus_addr != DAT_PORT)) |-> bus_rdata == 8'hFF);
  // R8: unmapped writes change no state
  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != IDX_PORT && bus_addr != DAT_PORT)
      |=> ($stable(reg_flat) && $stable(idx_q) && $stable(locked_q)));
endmodule

// File: tb/cfg_index_port_tb.sv
`timescale 1ns/1ps
module cfg_index_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        mech_sel;

  int n_cmp = 0, n_bad = 0;

  // reference model state
  int m_idx, m_lock, m_mech;
  int m_reg [16];

  always #4 clk = ~clk;

  cfg_index_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mech_sel(mech_sel)
  );

  function automatic int model_read(int a, int rd);
    if (!rd) return 255;
    if (a == 34) return m_idx;
    if (a == 35) return (m_idx < 16) ? m_reg[m_idx] : 255;
    return 255;
  endfunction

  task automatic model_write(int a, int d);
    if (a == 34) m_idx = d;
    else if (a == 35) begin
      if (m_idx == 3) m_lock = (d != 105);
      if (!m_lock && (m_idx == 0 || m_idx == 6 || m_idx == 7)) begin
        m_reg[m_idx] = d;
        if (m_idx == 0) m_mech = (d != 200);
      end
    end
  endtask

  task automatic model_reset();
    m_idx = 0; m_lock = 1; m_mech = 0;
    for (int i = 0; i < 16; i++) m_reg[i] = 0;
    m_reg[0] = 255;
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one bus cycle: drive, compare against model, clock, update model
  task automatic step(string req, int wr, int rd, int a, int d);
    @(negedge clk);
    bus_wr = wr[0]; bus_rd = rd[0]; bus_addr = a[15:0]; bus_wdata = d[7:0];
    #2;
    check(req, "rdata", int'(bus_rdata), model_read(a, rd));
    check(req, "mech_sel", int'(mech_sel), m_mech);
    @(posedge clk);
    #1;
    if (wr) model_write(a, d);
  endtask

  task automatic wr_reg(string req, int idx, int d);
    step(req, 1, 0, 34, idx);
    step(req, 1, 0, 35, d);
  endtask

  task automatic rd_reg(string req, int idx);
    step(req, 1, 0, 34, idx);
    step(req, 0, 1, 35, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7 / R1: reset contents, index and mechanism level
    step("R1", 0, 1, 34, 0);
    for (int i = 0; i < 16; i++) rd_reg("R7", i);

    // R3: writes while guarded change nothing
    wr_reg("R3", 0, 8'h11);
    wr_reg("R3", 6, 8'h22);
    wr_reg("R3", 7, 8'h33);
    rd_reg("R3", 0); rd_reg("R3", 6); rd_reg("R3", 7);

    // R2: open the guard with the key
    wr_reg("R2", 3, 8'h69);
    // R6: the off code drives the level low, other bytes high
    wr_reg("R6", 0, 8'hC8);
    rd_reg("R6", 0);
    wr_reg("R6", 0, 8'h12);
    rd_reg("R6", 0);
    wr_reg("R6", 0, 8'hFF);
    // R4: writable and non-writable indices
    wr_reg("R4", 6, 8'hA5);
    wr_reg("R4", 7, 8'h5A);
    wr_reg("R4", 1, 8'h77);
    wr_reg("R4", 5, 8'h78);
    wr_reg("R4", 15, 8'h79);
    for (int i = 0; i < 16; i++) rd_reg("R4", i);
    // R9: guard index reads its storage, not the guard
    rd_reg("R9", 3);
    // R5: out-of-bank indices read 0xFF and ignore writes
    rd_reg("R5", 16'h10);
    rd_reg("R5", 8'hFF);
    wr_reg("R5", 8'h40, 8'h99);
    rd_reg("R5", 0);
    // R1: index read back
    step("R1", 1, 0, 34, 8'h9C);
    step("R1", 0, 1, 34, 0);
    // R8: unmapped addresses and idle reads
    step("R8", 1, 0, 16'h0021, 8'h07);
    step("R8", 1, 0, 16'h0024, 8'h55);
    step("R8", 1, 0, 16'h1023, 8'h55);
    step("R8", 0, 1, 16'h0024, 0);
    step("R8", 0, 1, 16'h0122, 0);
    step("R8", 0, 0, 16'h0022, 0);
    step("R1", 0, 1, 34, 0);
    // R2: close the guard with a wrong byte, then confirm writes bounce
    wr_reg("R2", 3, 8'h68);
    wr_reg("R3", 6, 8'h01);
    wr_reg("R3", 0, 8'hC8);
    rd_reg("R3", 6);
    rd_reg("R9", 3);

    // randomized mix against the model
    for (int k = 0; k < 2000; k++) begin
      int sel, a, d, w;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? 34 : (sel < 8) ? 35 : (sel == 8) ? 33 : 36;
      w = $urandom_range(0, 1);
      d = (a == 34) ? ($urandom_range(0, 7) == 0 ? $urandom_range(0, 255)
                                                : $urandom_range(0, 15))
                    : ($urandom_range(0, 2) == 0 ? 105 :
                       ($urandom_range(0, 3) == 0 ? 200 : $urandom_range(0, 255)));
      step("R4", w, 1 - w, a, d);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule